// File: doc/BRIEF.md
# Keyboard Character Window

This block presents keyboard input to a processor as a small region of its 16-bit word-addressed memory. Each nonzero key code on the input is stored in one of sixteen word slots. The slots sit at a fixed base address, 0x9000 by default, and are filled in circular order. The processor finds new characters by reading the slots as ordinary memory. It hands a slot back by writing zero to it, because zero in a slot means "no character".

The block sits on the processor's memory bus in front of main memory. An address inside the sixteen-word window is served by the slot store. Any other address goes through unchanged to the main memory port. Software sees no pointer or count register. The device keeps its own write position. It never overwrites a slot that still holds an unread character. Instead it drops the key and raises a sticky overflow indication. When the processor writes the slot the device is about to fill, in the same cycle, the processor wins and the device retries on the following cycle.

Top module: `kbd_ring_window`

## Requirements
- R1: After reset, all sixteen slots read as zero, `key_overflow` is 0, and the first stored key lands in slot 0 (address base+0).
- R2: A processor read at an address from base+0 to base+15 returns the content of slot (address mod 16) in the same cycle. Reading has no side effect: repeated reads return the same value, and `mem_wr` stays 0 for window writes.
- R3: An address outside the window is passed to the memory port. `mem_addr` and `mem_wdata` follow the processor bus, `mem_wr` follows `cpu_wr`, and `cpu_rdata` returns `mem_rdata`. The slots are not touched.
- R4: A nonzero key code with `key_valid` high is written into the slot at the internal write position in that clock cycle. The position then advances by one, wrapping from 15 to 0.
- R5: A key code of zero is ignored. No slot changes and the write position does not advance.
- R6: If the slot at the write position is nonzero, the incoming key is dropped. That slot keeps its value, the write position stays where it is, and `key_overflow` becomes 1 and stays 1 until reset.
- R7: A processor write inside the window stores the data word in the addressed slot. Writing zero frees the slot for the device.
- R8: When a processor write and a device store target the same slot in the same cycle, the processor data is stored. The key is retried one cycle later against the new slot content: it is stored if that content is zero, and dropped with overflow otherwise.
- R9: A key that arrives in the cycle a retry is performed is held and stored on the following cycle, so characters stay in arrival order. If the retry is blocked again in that cycle, the new key is dropped and `key_overflow` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | A key code is present this cycle |
| key_code | input | 16 | Key code (0 is ignored) |
| cpu_addr | input | 16 | Processor word address |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Read data returned to the processor |
| mem_addr | output | 16 | Address forwarded to main memory |
| mem_wr | output | 1 | Write strobe forwarded to main memory (outside the window only) |
| mem_wdata | output | 16 | Write data forwarded to main memory |
| mem_rdata | input | 16 | Read data from main memory |
| key_overflow | output | 1 | Sticky flag: a key was lost |

## Verification
The hardest case to reach is the retry path. A key must arrive exactly when the processor writes the slot at the hidden write position, and the bench cannot see that position. The bench gets there from reset, where the position is known to be 0, and then counts every accepted key. In the colliding cycle it drives the processor write and the key together. It chooses zero or nonzero processor data to steer the retry toward storing or dropping, and presents a second key in the retry cycle to exercise the hold path.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    localparam int unsigned KBD_DATA_W = 16;
    localparam int unsigned KBD_ADDR_W = 16;
    localparam int unsigned KBD_IDX_W  = 4;
    localparam logic [15:0] KBD_BASE   = 16'h9000;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_STORE = 2'd1,
        ACT_DROP  = 2'd2,
        ACT_RETRY = 2'd3
    } kbd_act_e;
endpackage

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode #(
    parameter int unsigned ADDR_W = kbd_pkg::KBD_ADDR_W,
    parameter int unsigned IDX_W  = kbd_pkg::KBD_IDX_W,
    parameter logic [ADDR_W-1:0] BASE = kbd_pkg::KBD_BASE
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned TAG_W = ADDR_W - IDX_W;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:IDX_W];

    always_comb begin
        hit = (addr[ADDR_W-1:IDX_W] == BASE_TAG);
        idx = addr[IDX_W-1:0];
    end

    initial begin
        if (BASE[IDX_W-1:0] != '0) $error("window base must be aligned to the window size");
    end
endmodule

// File: rtl/kbd_slot_store.sv
module kbd_slot_store #(
    parameter int unsigned DATA_W = kbd_pkg::KBD_DATA_W,
    parameter int unsigned IDX_W  = kbd_pkg::KBD_IDX_W,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cpu_we,
    input  logic [IDX_W-1:0]              cpu_idx,
    input  logic [DATA_W-1:0]             cpu_data,
    input  logic                          dev_we,
    input  logic [IDX_W-1:0]              dev_idx,
    input  logic [DATA_W-1:0]             dev_data,
    output logic [DEPTH-1:0][DATA_W-1:0]  slots_q
);
    logic [DEPTH-1:0][DATA_W-1:0] slots_d;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            slots_d[g] = slots_q[g];
            if (cpu_we && (cpu_idx == IDX_W'(g))) begin
                slots_d[g] = cpu_data;
            end else if (dev_we && (dev_idx == IDX_W'(g))) begin
                slots_d[g] = dev_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slots_q[g] <= '0;
            else        slots_q[g] <= slots_d[g];
        end
    end

    // R7 / R8: a processor write always lands, even against a device store
    p_cpu_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |=> slots_q[$past(cpu_idx)] == $past(cpu_data));

    // R4: a device store lands when the processor is elsewhere
    p_dev_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_we && !(cpu_we && cpu_idx == dev_idx)) |=> slots_q[$past(dev_idx)] == $past(dev_data));
endmodule

// File: rtl/kbd_producer.sv
module kbd_producer #(
    parameter int unsigned DATA_W = kbd_pkg::KBD_DATA_W,
    parameter int unsigned IDX_W  = kbd_pkg::KBD_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [DATA_W-1:0] key_code,
    input  logic              cpu_we,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [DATA_W-1:0] cur_slot,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              dev_we,
    output logic [DATA_W-1:0] dev_data,
    output logic              overflow
);
    import kbd_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic              pend_v;
        logic [DATA_W-1:0] pend_d;
        logic              ovf;
    } prod_state_t;

    prod_state_t st_q, st_d;
    kbd_act_e    act;
    logic        in_v, src_v, collide, lost_in;
    logic [DATA_W-1:0] src_d;

    always_comb begin
        st_d    = st_q;
        in_v    = key_valid && (key_code != '0);
        src_v   = st_q.pend_v || in_v;
        src_d   = st_q.pend_v ? st_q.pend_d : key_code;
        collide = src_v && cpu_we && (cpu_idx == st_q.idx);
        lost_in = 1'b0;

        if (!src_v)                act = ACT_IDLE;
        else if (collide)          act = ACT_RETRY;
        else if (cur_slot != '0)   act = ACT_DROP;
        else                       act = ACT_STORE;

        st_d.pend_v = 1'b0;
        case (act)
            ACT_RETRY: begin
                st_d.pend_v = 1'b1;
                st_d.pend_d = src_d;
                lost_in     = st_q.pend_v && in_v;
            end
            ACT_STORE: begin
                st_d.idx = st_q.idx + 1'b1;
            end
            default: ;
        endcase

        if (act != ACT_RETRY && st_q.pend_v && in_v) begin
            st_d.pend_v = 1'b1;
            st_d.pend_d = key_code;
        end

        if (act == ACT_DROP || lost_in) st_d.ovf = 1'b1;

        dev_we   = (act == ACT_STORE);
        dev_data = src_d;
        wr_idx   = st_q.idx;
        overflow = st_q.ovf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the write position steps by exactly one after each store
    p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |=> wr_idx == $past(wr_idx) + 1'b1);

    // R6: without a store the write position holds
    p_idx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_we |=> $stable(wr_idx));

    // R6: overflow is sticky
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R5: the empty marker is never stored by the device
    p_no_zero_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> dev_data != '0);
endmodule

// File: rtl/kbd_ring_window.sv
module kbd_ring_window #(
    parameter int unsigned ADDR_W = kbd_pkg::KBD_ADDR_W,
    parameter int unsigned DATA_W = kbd_pkg::KBD_DATA_W,
    parameter int unsigned IDX_W  = kbd_pkg::KBD_IDX_W,
    parameter logic [ADDR_W-1:0] BASE = kbd_pkg::KBD_BASE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [DATA_W-1:0] key_code,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              key_overflow
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic                         win_hit;
    logic [IDX_W-1:0]             win_idx;
    logic                         cpu_we_win;
    logic [DEPTH-1:0][DATA_W-1:0] slots;
    logic [IDX_W-1:0]             wr_idx;
    logic                         dev_we;
    logic [DATA_W-1:0]            dev_data;

    kbd_addr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) i_decode (
        .addr (cpu_addr),
        .hit  (win_hit),
        .idx  (win_idx)
    );

    always_comb begin
        cpu_we_win = cpu_wr && win_hit;
        mem_addr   = cpu_addr;
        mem_wdata  = cpu_wdata;
        mem_wr     = cpu_wr && !win_hit;
        cpu_rdata  = win_hit ? slots[win_idx] : mem_rdata;
    end

    kbd_producer #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_producer (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_code  (key_code),
        .cpu_we    (cpu_we_win),
        .cpu_idx   (win_idx),
        .cur_slot  (slots[wr_idx]),
        .wr_idx    (wr_idx),
        .dev_we    (dev_we),
        .dev_data  (dev_data),
        .overflow  (key_overflow)
    );

    kbd_slot_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_we   (cpu_we_win),
        .cpu_idx  (win_idx),
        .cpu_data (cpu_wdata),
        .dev_we   (dev_we),
        .dev_idx  (wr_idx),
        .dev_data (dev_data),
        .slots_q  (slots)
    );

    // R3: traffic outside the window leaves the slots untouched
    p_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_we_win && !dev_we) |=> $stable(slots));

    // R2: window writes never reach main memory
    p_no_mem_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && win_hit) |-> !mem_wr);

    // R6: a device store only ever fills an empty slot
    p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |-> slots[wr_idx] == '0);
endmodule

// File: tb/test_kbd_ring_window.sv
module test_kbd_ring_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_valid = 1'b0;
    logic [15:0] key_code = '0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic [15:0] mem_addr;
    logic        mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'hBEEF;
    logic        key_overflow;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam logic [15:0] WB = 16'h9000;

    always #5 clk = ~clk;

    kbd_ring_window i_kbd_ring_window (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .key_overflow(key_overflow)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        key_valid = 1'b0; cpu_wr = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic slot(input int i, output logic [15:0] v);
        cpu_wr = 1'b0;
        cpu_addr = WB + 16'(i);
        #1 v = cpu_rdata;
    endtask

    task automatic key(input logic [15:0] c);
        key_valid = 1'b1; key_code = c;
        tick();
        key_valid = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        tick();
        cpu_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        for (int i = 0; i < 16; i++) begin
            slot(i, v);
            chk("R1 slot zero after reset", v, 16'h0);
        end
        chk("R1 overflow clear", 16'(key_overflow), 16'h0);
        key(16'h0031);
        slot(0, v);
        chk("R1 first key in slot 0", v, 16'h0031);
    endtask

    task automatic t_passthrough();
        logic [15:0] v;
        do_reset();
        cpu_addr = 16'h1234; cpu_wdata = 16'hA5A5; cpu_wr = 1'b1;
        #1;
        chk("R3 mem_wr", 16'(mem_wr), 16'h1);
        chk("R3 mem_addr", mem_addr, 16'h1234);
        chk("R3 mem_wdata", mem_wdata, 16'hA5A5);
        cpu_addr = 16'h9010;
        #1 chk("R3 above window passes", 16'(mem_wr), 16'h1);
        cpu_addr = 16'h8FFF;
        #1 chk("R3 below window passes", 16'(mem_wr), 16'h1);
        tick();
        cpu_wr = 1'b0;
        cpu_addr = 16'h8FFF;
        #1 chk("R3 read from memory", cpu_rdata, 16'hBEEF);
        for (int i = 0; i < 16; i++) begin
            slot(i, v);
            chk("R3 slots untouched", v, 16'h0);
        end
        cpu_addr = WB + 16'hF; cpu_wdata = 16'h0777; cpu_wr = 1'b1;
        #1 chk("R2 window write not forwarded", 16'(mem_wr), 16'h0);
        tick();
        cpu_wr = 1'b0;
        slot(15, v);
        chk("R7 cpu write stored at top slot", v, 16'h0777);
        slot(15, v);
        chk("R2 repeat read unchanged", v, 16'h0777);
    endtask

    task automatic t_zero_and_order();
        logic [15:0] v;
        do_reset();
        key(16'h0041);
        key(16'h0000);
        slot(1, v);
        chk("R5 zero key ignored", v, 16'h0);
        key(16'h0042);
        slot(1, v);
        chk("R5 position not advanced by zero key", v, 16'h0042);
        slot(0, v);
        chk("R2 read has no side effect", v, 16'h0041);
    endtask

    task automatic t_wrap_full();
        logic [15:0] v;
        do_reset();
        for (int i = 0; i < 16; i++) key(16'h0100 + 16'(i));
        slot(15, v);
        chk("R4 slot 15 filled", v, 16'h010F);
        chk("R6 no overflow yet", 16'(key_overflow), 16'h0);
        key(16'h0999);
        slot(0, v);
        chk("R6 full slot not overwritten", v, 16'h0100);
        chk("R6 overflow set", 16'(key_overflow), 16'h1);
        wr(WB, 16'h0000);
        slot(0, v);
        chk("R7 zero write frees slot", v, 16'h0);
        key(16'h0222);
        slot(0, v);
        chk("R4 wrap to slot 0", v, 16'h0222);
        chk("R6 overflow sticky", 16'(key_overflow), 16'h1);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        do_reset();
        cpu_addr = WB; cpu_wdata = 16'h0000; cpu_wr = 1'b1;
        key_valid = 1'b1; key_code = 16'h0055;
        tick();
        cpu_wr = 1'b0; key_valid = 1'b0;
        slot(0, v);
        chk("R8 cpu wins collision cycle", v, 16'h0);
        tick();
        slot(0, v);
        chk("R8 retried key stored", v, 16'h0055);
        chk("R8 no overflow on stored retry", 16'(key_overflow), 16'h0);

        do_reset();
        cpu_addr = WB; cpu_wdata = 16'h0077; cpu_wr = 1'b1;
        key_valid = 1'b1; key_code = 16'h0066;
        tick();
        cpu_wr = 1'b0; key_valid = 1'b0;
        tick();
        slot(0, v);
        chk("R8 cpu data kept", v, 16'h0077);
        chk("R8 retry dropped sets overflow", 16'(key_overflow), 16'h1);
    endtask

    task automatic t_retry_hold();
        logic [15:0] v;
        do_reset();
        cpu_addr = WB; cpu_wdata = 16'h0000; cpu_wr = 1'b1;
        key_valid = 1'b1; key_code = 16'h0061;
        tick();
        cpu_wr = 1'b0;
        key_code = 16'h0062;
        tick();
        key_valid = 1'b0;
        tick();
        slot(0, v);
        chk("R9 retried key first", v, 16'h0061);
        slot(1, v);
        chk("R9 held key second", v, 16'h0062);
        chk("R9 no loss", 16'(key_overflow), 16'h0);

        do_reset();
        cpu_addr = WB; cpu_wdata = 16'h0000; cpu_wr = 1'b1;
        key_valid = 1'b1; key_code = 16'h0071;
        tick();
        key_code = 16'h0072;
        tick();
        cpu_wr = 1'b0; key_valid = 1'b0;
        tick();
        slot(0, v);
        chk("R9 twice-blocked key stored", v, 16'h0071);
        slot(1, v);
        chk("R9 new key dropped", v, 16'h0);
        chk("R9 loss flagged", 16'(key_overflow), 16'h1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        t_reset();
        t_passthrough();
        t_zero_and_order();
        t_wrap_full();
        t_collide();
        t_retry_hold();
        summary();
    end
endmodule